// File: doc/BRIEF.md
# Two-Write Memory-Mapped Reset Sequencer

This block lets a host restart the card through ordinary memory writes, for a host that can issue memory writes but has no path to I/O space. It watches a simple write bus: a one-cycle write strobe with a 32-bit address and 32-bit data. A reset takes an ordered pair of writes. The first write arms the sequencer. It goes to the top-of-memory address `0xFFFFFFF0` and chooses hard or soft. The second write goes to `0xFFFFFFF4` and triggers the reset. When the pair is accepted, the block drives a reset pulse of fixed length.

A hard reset asserts three outputs together: the CPU reset, the active-low bus reset and the legacy-device reset. A soft reset asserts only the CPU INIT line. Only data bits 1 and 2 carry meaning. Bit 2 is the trigger and must be 0 in the first write and 1 in the second. Bit 1 is the kind, 1 for hard and 0 for soft, and it must match in both writes. Every other data bit must be zero. The reset reaches the card's own logic only; the block has no output toward anything else.

Top module: `rstseq_top`

## Requirements
- R1: A write of data `0x02` or `0x00` to `0xFFFFFFF0` arms the sequencer. A following write to `0xFFFFFFF4` with the matching trigger data completes the sequence.
- R2: A hard sequence is `0x02` to `0xFFFFFFF0` followed by `0x06` to `0xFFFFFFF4`. It makes `cpu_rst`=1, `bus_rst_n`=0 and `legacy_rst`=1 together, with `cpu_init`=0.
- R3: A soft sequence is `0x00` to `0xFFFFFFF0` followed by `0x04` to `0xFFFFFFF4`. It makes `cpu_init`=1 and leaves `cpu_rst`=0, `bus_rst_n`=1 and `legacy_rst`=0.
- R4: The reset outputs rise in the cycle after the clock edge that samples the second write. They stay asserted for exactly `PULSE_CYCLES` cycles (default 16) and are then released.
- R5: While the sequencer is armed, any write that neither restarts nor completes the sequence returns it to idle. This covers another address, and the second address with wrong data. A later write to `0xFFFFFFF4` then has no effect.
- R6: A write to `0xFFFFFFF4` with no armed first step has no effect.
- R7: A valid first-step write while already armed re-arms the sequencer, and the most recent write sets the kind.
- R8: A nonzero data bit outside bits 1 and 2 prevents a match at either step.
- R9: A second write whose kind bit differs from the armed kind (for example armed hard, then `0x04`) causes no reset.
- R10: Writes are ignored while a pulse is active, so a full sequence written then starts no new pulse. After the pulse the sequencer is idle, and a write to `0xFFFFFFF4` alone does nothing.
- R11: During and after the synchronous reset `rst`, `cpu_rst`, `legacy_rst` and `cpu_init` are 0 and `bus_rst_n` is 1.
- R12: Cycles with `wr_en` low do not disturb an armed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 32 | Write address |
| wr_data | input | 32 | Write data |
| cpu_rst | output | 1 | CPU reset, active high (hard) |
| bus_rst_n | output | 1 | Bus reset, active low (hard) |
| legacy_rst | output | 1 | Legacy-device reset, active high (hard) |
| cpu_init | output | 1 | CPU INIT, active high (soft) |

## Verification
The hardest case to reach is a write that arrives while a pulse is still running. It must be dropped, and it must not leave the tracker armed once the pulse ends. The stimulus fires a hard reset and, within the pulse window, writes a complete soft sequence. After the pulse it sends a lone second-step write. The scoreboard must see exactly one hard pulse of the right width, and no soft pulse either during the window or after the lone write.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam logic [31:0] STEP1_ADDR = 32'hFFFF_FFF0;
    localparam logic [31:0] STEP2_ADDR = 32'hFFFF_FFF4;
    localparam int          TRIG_BIT   = 2;
    localparam int          KIND_BIT   = 1;
    localparam logic [31:0] MEANING_MASK = (32'h1 << TRIG_BIT) | (32'h1 << KIND_BIT);

    typedef enum logic { TRK_IDLE = 1'b0, TRK_ARMED = 1'b1 } trk_state_e;
    typedef enum logic { RST_SOFT = 1'b0, RST_HARD = 1'b1 } rst_kind_e;

    typedef struct packed {
        logic      any;    // a write happened this cycle
        logic      step1;  // valid arming write
        logic      step2;  // well-formed trigger write
        rst_kind_e kind;   // kind bit of this write
    } wr_class_t;

    function automatic wr_class_t classify(input logic        valid,
                                           input logic [31:0] addr,
                                           input logic [31:0] data);
        wr_class_t c;
        logic clean;
        clean   = ((data & ~MEANING_MASK) == 32'h0);
        c.any   = valid;
        c.kind  = rst_kind_e'(data[KIND_BIT]);
        c.step1 = valid && clean && (addr == STEP1_ADDR) && !data[TRIG_BIT];
        c.step2 = valid && clean && (addr == STEP2_ADDR) &&  data[TRIG_BIT];
        return c;
    endfunction

endpackage

// File: rtl/rstseq_decode.sv
module rstseq_decode
    import rstseq_pkg::*;
(
    input  logic        wr_en,
    input  logic [31:0] wr_addr,
    input  logic [31:0] wr_data,
    output wr_class_t   cls
);
    always_comb cls = classify(wr_en, wr_addr, wr_data);
endmodule

// File: rtl/rstseq_track.sv
module rstseq_track
    import rstseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      busy,
    input  wr_class_t cls,
    output logic      fire,
    output rst_kind_e fire_kind
);
    trk_state_e state_q;
    rst_kind_e  kind_q;

    always_comb begin
        fire      = !busy && (state_q == TRK_ARMED) && cls.step2 && (cls.kind == kind_q);
        fire_kind = kind_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRK_IDLE;
            kind_q  <= RST_SOFT;
        end else if (busy) begin
            state_q <= TRK_IDLE;
        end else if (cls.any) begin
            if (cls.step1) begin
                state_q <= TRK_ARMED;
                kind_q  <= cls.kind;
            end else begin
                state_q <= TRK_IDLE;
            end
        end
    end
endmodule

// File: rtl/rstseq_pulse.sv
module rstseq_pulse
    import rstseq_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  rst_kind_e fire_kind,
    output logic      active,
    output rst_kind_e kind
);
    localparam int CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            kind   <= RST_SOFT;
            cnt_q  <= '0;
        end else if (!active) begin
            if (fire) begin
                active <= 1'b1;
                kind   <= fire_kind;
                cnt_q  <= LOAD;
            end
        end else if (cnt_q == '0) begin
            active <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_addr,
    input  logic [31:0] wr_data,
    output logic        cpu_rst,
    output logic        bus_rst_n,
    output logic        legacy_rst,
    output logic        cpu_init
);
    wr_class_t cls;
    logic      fire;
    rst_kind_e fire_kind;
    logic      fire_hard;
    logic      active;
    rst_kind_e pulse_kind;
    logic      hard_on;

    rstseq_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cls     (cls)
    );

    rstseq_track u_trk (
        .clk       (clk),
        .rst       (rst),
        .busy      (active),
        .cls       (cls),
        .fire      (fire),
        .fire_kind (fire_kind)
    );

    rstseq_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pls (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .fire_kind (fire_kind),
        .active    (active),
        .kind      (pulse_kind)
    );

    assign fire_hard  = (fire_kind == RST_HARD);
    assign hard_on    = active && (pulse_kind == RST_HARD);
    assign cpu_rst    = hard_on;
    assign legacy_rst = hard_on;
    assign bus_rst_n  = !hard_on;
    assign cpu_init   = active && (pulse_kind == RST_SOFT);
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int PULSE_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic fire,
    input logic fire_hard,
    input logic cpu_rst,
    input logic bus_rst_n,
    input logic legacy_rst,
    input logic cpu_init
);
    logic pulse_on;
    int   run_len;

    assign pulse_on = cpu_rst || cpu_init;

    always_ff @(posedge clk) begin
        if (rst)           run_len <= 0;
        else if (pulse_on) run_len <= run_len + 1;
        else               run_len <= 0;
    end

    assert_hard_group_R2: assert property (@(posedge clk) disable iff (rst)
        fire && fire_hard |=> cpu_rst && !bus_rst_n && legacy_rst && !cpu_init);

    assert_soft_init_only_R3: assert property (@(posedge clk) disable iff (rst)
        fire && !fire_hard |=> cpu_init && !cpu_rst && bus_rst_n && !legacy_rst);

    assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (rst)
        pulse_on |-> run_len < PULSE_CYCLES);

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_on) |-> run_len == PULSE_CYCLES);

    assert_no_fire_busy_R10: assert property (@(posedge clk) disable iff (rst)
        fire |-> !pulse_on);
endmodule

bind rstseq_top rstseq_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire),
    .fire_hard  (fire_hard),
    .cpu_rst    (cpu_rst),
    .bus_rst_n  (bus_rst_n),
    .legacy_rst (legacy_rst),
    .cpu_init   (cpu_init)
);

// File: tb/tb_rstseq_top.sv
module tb_rstseq_top;
    localparam int P = 16;
    localparam logic [31:0] A1 = 32'hFFFF_FFF0;
    localparam logic [31:0] A2 = 32'hFFFF_FFF4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        cpu_rst, bus_rst_n, legacy_rst, cpu_init;

    always #4 clk = ~clk;

    rstseq_top #(.PULSE_CYCLES(P)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_rst(cpu_rst), .bus_rst_n(bus_rst_n), .legacy_rst(legacy_rst), .cpu_init(cpu_init)
    );

    typedef struct { bit hard; int start; } exp_t;
    exp_t q[$];

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // reference model state, built from the requirements
    bit m_arm = 0;
    bit m_hard = 0;
    bit have_p = 0;
    int ps = 0;

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        int  c;
        bit  busy;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        c = cyc;
        busy = have_p && (c >= ps + 1) && (c <= ps + P);
        if (busy) begin
            m_arm = 0;                                     // R10
        end else if (a == A1 && (d == 32'h0 || d == 32'h2)) begin
            m_arm = 1; m_hard = d[1];                      // R1 R7
        end else if (m_arm && a == A2 && d == (m_hard ? 32'h6 : 32'h4)) begin
            exp_t e;
            e.hard = m_hard; e.start = c;
            q.push_back(e);
            have_p = 1; ps = c; m_arm = 0;
        end else begin
            m_arm = 0;                                     // R5 R6 R8 R9
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor: pops expected pulses and compares
    bit pa = 0;
    bit kd = 0;
    int st = 0;
    int len = 0;
    bit bad_cons = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cpu_rst || cpu_init) begin
                if (!pa) begin st = cyc; kd = cpu_rst; len = 0; bad_cons = 0; end
                len++;
                if ((cpu_rst && cpu_init) || (legacy_rst != cpu_rst) || (bus_rst_n != !cpu_rst))
                    bad_cons = 1;
                pa = 1;
            end else if (pa) begin
                pa = 0;
                checks++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R6 unexpected pulse: actual hard=%0d start=%0d, expected none", kd, st);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.hard != kd || e.start != st || len != P || bad_cons) begin
                        fails++;
                        $display("FAIL %s pulse: actual hard=%0d start=%0d len=%0d cons_err=%0d, expected hard=%0d start=%0d len=%0d",
                                 kd ? "R2 R4" : "R3 R4", kd, st, len, bad_cons, e.hard, e.start, P);
                    end
                end
            end
        end
    end

    task automatic settle(input string tag);
        repeat (P + 6) @(negedge clk);
        checks++;
        if (q.size() != 0 || pa) begin
            fails++;
            $display("FAIL %s: actual pending=%0d active=%0d, expected pending=0 active=0", tag, q.size(), pa);
            q.delete();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (cpu_rst !== 1'b0 || bus_rst_n !== 1'b1 || legacy_rst !== 1'b0 || cpu_init !== 1'b0) begin
            fails++;
            $display("FAIL R11 in reset: actual %b%b%b%b, expected 0100", cpu_rst, bus_rst_n, legacy_rst, cpu_init);
        end
        rst = 1'b0;
        repeat (2) @(negedge clk);
        checks++;
        if (cpu_rst !== 1'b0 || bus_rst_n !== 1'b1 || legacy_rst !== 1'b0 || cpu_init !== 1'b0) begin
            fails++;
            $display("FAIL R11 after reset: actual %b%b%b%b, expected 0100", cpu_rst, bus_rst_n, legacy_rst, cpu_init);
        end

        // R1 R2 R4: hard sequence
        wr(A1, 32'h2); wr(A2, 32'h6); settle("R2 hard");
        // R3: soft sequence
        wr(A1, 32'h0); wr(A2, 32'h4); settle("R3 soft");
        // R6: second step alone
        wr(A2, 32'h6); settle("R6 lone step2");
        // R5: foreign address aborts
        wr(A1, 32'h2); wr(32'h0000_1000, 32'h6); wr(A2, 32'h6); settle("R5 abort other addr");
        // R5: wrong data at step2 aborts
        wr(A1, 32'h2); wr(A2, 32'h2); wr(A2, 32'h6); settle("R5 abort bad data");
        // R7: re-arm changes kind
        wr(A1, 32'h2); wr(A1, 32'h0); wr(A2, 32'h4); settle("R7 rearm soft");
        wr(A1, 32'h0); wr(A1, 32'h2); wr(A2, 32'h6); settle("R7 rearm hard");
        // R8: stray data bits
        wr(A1, 32'h82); wr(A2, 32'h6); settle("R8 stray step1");
        wr(A1, 32'h2); wr(A2, 32'h106); settle("R8 stray step2");
        // R9: kind mismatch
        wr(A1, 32'h2); wr(A2, 32'h4); settle("R9 hard then soft");
        wr(A1, 32'h0); wr(A2, 32'h6); settle("R9 soft then hard");
        // R10: writes during a pulse are dropped
        wr(A1, 32'h2); wr(A2, 32'h6); wr(A1, 32'h0); wr(A2, 32'h4); settle("R10 during pulse");
        wr(A2, 32'h4); settle("R10 idle after pulse");
        // R12: idle gap between steps
        wr(A1, 32'h0);
        repeat (5) @(negedge clk);
        wr(A2, 32'h4); settle("R12 gap");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule